// File: doc/BRIEF.md
# CAN Controller Interrupt Status Logic

This block holds the eight interrupt flags of a CAN protocol controller and shows them to a host CPU as one read-only 8-bit register. It also drives one combined interrupt line. The CAN core supplies the events and status levels. The block turns each of these into a flag according to that source's own rule: a plain level, a rising edge, or a change in either direction. Each rule is gated by an enable bit for that source.

A host read of the register clears every latched flag. The receive flag is the exception: it follows a live condition, either the receive FIFO fill level or a pending high-priority message.

Two of the sources have a lock, the bus-error source and the arbitration-lost source. Once one of them has raised its flag, it cannot raise another until the host has read the matching capture register. This keeps the captured diagnostic data and the interrupt tied to each other.

Top module: `can_irq_status`

## Requirements
- R1: While reset is asserted, and after it is released, `irq_reg` is 0 and `irq_out` is 0. Both locks are clear. The first clock edge after reset only records the status inputs as a baseline, so a status input that is already 1 at that edge raises no flag.
- R2: `irq_out` is 1 exactly when `irq_reg` is nonzero, in the same cycle.
- R3: A cycle with `host_rd`=1 clears bits 7 to 1 of `irq_reg` from the next cycle on. Bit 0 is not cleared by the read. If a set condition for a bit occurs in the same cycle as the read, that bit is 1 afterwards.
- R4: Bit 7 (bus error) sets when `bus_err_evt`=1, `int_en[7]`=1 and the bus-error lock is clear. That event also sets the lock. While the lock is set, `bus_err_evt` raises nothing. A cycle with `err_cap_rd`=1 clears the lock for the following cycles. An unlocked event in the same cycle as `err_cap_rd` still sets both the flag and the lock.
- R5: Bit 6 (arbitration lost) follows the same rule as R4, using `arb_lost_evt`, `int_en[6]`, its own lock and `arb_cap_rd`.
- R6: Bit 5 (error passive) sets when `int_en[5]`=1 and `err_passive` changes in either direction between two consecutive clock edges.
- R7: Bit 4 (wake-up) sets in every cycle in which `sleep_mode`, `bus_activity` and `int_en[4]` are all 1.
- R8: Bit 3 (data overrun) sets only when `overrun_stat` goes from 0 to 1 with `int_en[3]`=1. A 1-to-0 change does not set it.
- R9: Bit 2 (error) sets when `int_en[2]`=1 and either `err_stat` or `bus_stat` changes in either direction.
- R10: Bit 1 (transmit) sets only when `tx_buf_free` goes from 0 to 1 with `int_en[1]`=1.
- R11: Bit 0 (receive) equals, one cycle later, `int_en[0]` AND (`rx_count` > `rx_level` OR `hp_pending`). It stays set through host reads for as long as the condition holds.
- R12: A flag whose enable bit is 0 does not set. An edge that occurs while the enable is 0 is not remembered. Every flag appears in `irq_reg` one clock after the edge at which its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_err_evt | input | 1 | Bus error detected, one-cycle pulse |
| arb_lost_evt | input | 1 | Arbitration lost, one-cycle pulse |
| err_passive | input | 1 | Controller is error passive (an error counter is above 127) |
| sleep_mode | input | 1 | Controller is sleeping |
| bus_activity | input | 1 | Activity seen on the bus |
| overrun_stat | input | 1 | Data overrun status level |
| err_stat | input | 1 | Error status level |
| bus_stat | input | 1 | Bus status level |
| tx_buf_free | input | 1 | Transmit buffer released |
| rx_count | input | CNT_W | Bytes held in the receive FIFO |
| rx_level | input | CNT_W | Programmed receive interrupt threshold |
| hp_pending | input | 1 | Message that passed a high-priority filter is pending |
| int_en | input | 8 | Per-flag enables, same bit positions as `irq_reg` |
| host_rd | input | 1 | Host read of the interrupt register |
| err_cap_rd | input | 1 | Host read of the error code capture register |
| arb_cap_rd | input | 1 | Host read of the arbitration lost capture register |
| irq_reg | output | 8 | Interrupt register value |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The hardest situations to reach are the ones where two actions fall in the same cycle. Examples are a lock release meeting a new event, and a set condition meeting a host read. Both depend on pulses being aligned to the exact clock.

The stimulus places the capture-register read and the source event in the same cycle, both with the lock held and with the lock free. It also raises level and edge sources in the very cycle of a host read. A pseudorandom phase then mixes every input, including reads, so that many more of these collisions occur. Throughout, a behavioural model is compared with the outputs on every cycle.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int NUM_FLAGS = 8;

    // flag positions inside the host-visible register
    localparam int F_RX   = 0;
    localparam int F_TX   = 1;
    localparam int F_ERR  = 2;
    localparam int F_OVR  = 3;
    localparam int F_WAKE = 4;
    localparam int F_PASV = 5;
    localparam int F_ARB  = 6;
    localparam int F_BUS  = 7;

    // inputs watched by the change detector
    localparam int EDGE_N  = 5;
    localparam int E_TX    = 0;
    localparam int E_OVR   = 1;
    localparam int E_ERRST = 2;
    localparam int E_BUSST = 3;
    localparam int E_PASV  = 4;

    // 1 = either direction counts, 0 = only 0-to-1 counts
    localparam logic [EDGE_N-1:0] EDGE_ANY_MASK = 5'b11100;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
        logic                 irq;
    } irq_state_t;

endpackage

// File: rtl/can_irq_edge.sv
module can_irq_edge #(
    parameter int                N        = 5,
    parameter logic [N-1:0]      ANY_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] hit
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic         armed;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = sig;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_det
        if (ANY_MASK[i]) begin : g_any
            assign hit[i] = st_q.armed & (sig[i] ^ st_q.prev[i]);
        end else begin : g_rise
            assign hit[i] = st_q.armed & sig[i] & ~st_q.prev[i];

            // R8
            rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |-> (sig[i] && !st_q.prev[i]))
                else $error("rise detector fired without a 0-to-1 change");
        end
    end

    // R1
    baseline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> (hit == '0))
        else $error("change reported before baseline captured");

endmodule

// File: rtl/can_irq_lock.sv
module can_irq_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic en,
    input  logic cap_rd,
    output logic set,
    output logic locked
);

    logic lock_d, lock_q;

    always_comb begin
        set    = evt & en & ~lock_q;
        lock_d = set | (lock_q & ~cap_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign locked = lock_q;

    // R4
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !set)
        else $error("event passed while locked");

    // R4
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cap_rd) |=> !locked)
        else $error("capture read did not release lock");

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cap_rd) |=> locked)
        else $error("lock dropped without capture read");

endmodule

// File: rtl/can_irq_status.sv
module can_irq_status
    import can_irq_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_err_evt,
    input  logic                 arb_lost_evt,
    input  logic                 err_passive,
    input  logic                 sleep_mode,
    input  logic                 bus_activity,
    input  logic                 overrun_stat,
    input  logic                 err_stat,
    input  logic                 bus_stat,
    input  logic                 tx_buf_free,
    input  logic [CNT_W-1:0]     rx_count,
    input  logic [CNT_W-1:0]     rx_level,
    input  logic                 hp_pending,
    input  logic [NUM_FLAGS-1:0] int_en,
    input  logic                 host_rd,
    input  logic                 err_cap_rd,
    input  logic                 arb_cap_rd,
    output logic [NUM_FLAGS-1:0] irq_reg,
    output logic                 irq_out
);

    localparam int LATCH_HI = NUM_FLAGS - 1;

    logic [EDGE_N-1:0]    watch;
    logic [EDGE_N-1:0]    chg;
    logic [NUM_FLAGS-1:0] set_vec;
    logic                 bus_lk, arb_lk;
    logic                 bus_set, arb_set;
    logic                 rx_live;

    irq_state_t st_d, st_q;

    always_comb begin
        watch          = '0;
        watch[E_TX]    = tx_buf_free;
        watch[E_OVR]   = overrun_stat;
        watch[E_ERRST] = err_stat;
        watch[E_BUSST] = bus_stat;
        watch[E_PASV]  = err_passive;
    end

    can_irq_edge #(
        .N        (EDGE_N),
        .ANY_MASK (EDGE_ANY_MASK)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (watch),
        .hit   (chg)
    );

    can_irq_lock u_bus_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (bus_err_evt),
        .en     (int_en[F_BUS]),
        .cap_rd (err_cap_rd),
        .set    (bus_set),
        .locked (bus_lk)
    );

    can_irq_lock u_arb_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (arb_lost_evt),
        .en     (int_en[F_ARB]),
        .cap_rd (arb_cap_rd),
        .set    (arb_set),
        .locked (arb_lk)
    );

    always_comb begin
        rx_live         = (rx_count > rx_level) | hp_pending;
        set_vec         = '0;
        set_vec[F_BUS]  = bus_set;
        set_vec[F_ARB]  = arb_set;
        set_vec[F_PASV] = int_en[F_PASV] & chg[E_PASV];
        set_vec[F_WAKE] = int_en[F_WAKE] & sleep_mode & bus_activity;
        set_vec[F_OVR]  = int_en[F_OVR] & chg[E_OVR];
        set_vec[F_ERR]  = int_en[F_ERR] & (chg[E_ERRST] | chg[E_BUSST]);
        set_vec[F_TX]   = int_en[F_TX] & chg[E_TX];
        set_vec[F_RX]   = int_en[F_RX] & rx_live;
    end

    always_comb begin
        st_d = st_q;
        st_d.flags[LATCH_HI:1] = set_vec[LATCH_HI:1]
                               | (st_q.flags[LATCH_HI:1] & {LATCH_HI{~host_rd}});
        st_d.flags[F_RX] = set_vec[F_RX];
        st_d.irq = |st_d.flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_reg = st_q.flags;
    assign irq_out = st_q.irq;

    // R2
    irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (irq_reg != '0))
        else $error("interrupt line disagrees with register");

    for (genvar k = 1; k < NUM_FLAGS; k++) begin : g_flag_chk
        // R3
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_rd && !set_vec[k]) |=> !irq_reg[k])
            else $error("flag survived host read");

        // R3
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[k] |=> irq_reg[k])
            else $error("set event lost");

        // R12
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_reg[k] && !host_rd) |=> irq_reg[k])
            else $error("flag dropped without read");
    end

    // R12
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en[F_OVR] && !irq_reg[F_OVR] && !host_rd) |=> !irq_reg[F_OVR])
        else $error("disabled overrun flag set");

endmodule

// File: tb/can_irq_status_test.sv
module can_irq_status_test;

    localparam int CNT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_err_evt = 0, arb_lost_evt = 0, err_passive = 0;
    logic sleep_mode = 0, bus_activity = 0, overrun_stat = 0;
    logic err_stat = 0, bus_stat = 0, tx_buf_free = 1;
    logic [CNT_W-1:0] rx_count = '0, rx_level = 7'd8;
    logic hp_pending = 0;
    logic [7:0] int_en = 8'hFF;
    logic host_rd = 0, err_cap_rd = 0, arb_cap_rd = 0;
    logic [7:0] irq_reg;
    logic irq_out;

    can_irq_status #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_err_evt(bus_err_evt), .arb_lost_evt(arb_lost_evt),
        .err_passive(err_passive), .sleep_mode(sleep_mode),
        .bus_activity(bus_activity), .overrun_stat(overrun_stat),
        .err_stat(err_stat), .bus_stat(bus_stat), .tx_buf_free(tx_buf_free),
        .rx_count(rx_count), .rx_level(rx_level), .hp_pending(hp_pending),
        .int_en(int_en), .host_rd(host_rd), .err_cap_rd(err_cap_rd),
        .arb_cap_rd(arb_cap_rd), .irq_reg(irq_reg), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference model
    bit [7:0] m_reg;
    bit m_irq, m_be_lock, m_al_lock, m_armed;
    int p_tx, p_ovr, p_es, p_bs, p_ep;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 0; m_irq = 0; m_be_lock = 0; m_al_lock = 0; m_armed = 0;
            p_tx = 0; p_ovr = 0; p_es = 0; p_bs = 0; p_ep = 0;
        end else begin
            bit [7:0] nxt;
            bit be, al;
            nxt = host_rd ? (m_reg & 8'h01) : m_reg;
            be = bus_err_evt && int_en[7] && !m_be_lock;
            al = arb_lost_evt && int_en[6] && !m_al_lock;
            if (be) begin nxt[7] = 1; m_be_lock = 1; end
            else if (err_cap_rd) m_be_lock = 0;
            if (al) begin nxt[6] = 1; m_al_lock = 1; end
            else if (arb_cap_rd) m_al_lock = 0;
            if (m_armed) begin
                if (int_en[5] && int'(err_passive) != p_ep) nxt[5] = 1;
                if (int_en[3] && overrun_stat && p_ovr == 0) nxt[3] = 1;
                if (int_en[2] && (int'(err_stat) != p_es || int'(bus_stat) != p_bs)) nxt[2] = 1;
                if (int_en[1] && tx_buf_free && p_tx == 0) nxt[1] = 1;
            end
            if (int_en[4] && sleep_mode && bus_activity) nxt[4] = 1;
            nxt[0] = int_en[0] && ((int'(rx_count) > int'(rx_level)) || hp_pending);
            m_reg = nxt;
            m_irq = (nxt != 0);
            p_tx = tx_buf_free; p_ovr = overrun_stat; p_es = err_stat;
            p_bs = bus_stat; p_ep = err_passive; m_armed = 1;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (irq_reg !== m_reg || irq_out !== m_irq) begin
                mismatched++;
                $display("FAIL %s: irq_reg=%02h irq_out=%0b expected %02h/%0b",
                         cur_req, irq_reg, irq_out, m_reg, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic hread();
        host_rd = 1; tick(); host_rd = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset with tx_buf_free already high
        cur_req = "R1";
        tick(3);
        @(negedge clk); chk("R1", irq_reg, 8'h00); chk("R1", {7'd0, irq_out}, 8'h00);
        rst_n = 1;
        tick(3);
        @(negedge clk); chk("R1", irq_reg, 8'h00);

        // R8: overrun rise sets, fall does not
        cur_req = "R8";
        overrun_stat = 1; tick();
        @(negedge clk); chk("R8", irq_reg, 8'h08); chk("R2", {7'd0, irq_out}, 8'h01);
        hread(); overrun_stat = 0; tick(2);
        @(negedge clk); chk("R8", irq_reg, 8'h00);

        // R10: transmit released
        cur_req = "R10";
        tx_buf_free = 0; tick(2);
        @(negedge clk); chk("R10", irq_reg, 8'h00);
        tx_buf_free = 1; tick();
        @(negedge clk); chk("R10", irq_reg, 8'h02);
        hread();

        // R9: error / bus status either direction
        cur_req = "R9";
        err_stat = 1; tick(); hread();
        err_stat = 0; tick();
        @(negedge clk); chk("R9", irq_reg, 8'h04);
        hread(); bus_stat = 1; tick(); hread(); bus_stat = 0; tick(); hread();

        // R6: error passive both ways
        cur_req = "R6";
        err_passive = 1; tick();
        @(negedge clk); chk("R6", irq_reg, 8'h20);
        hread(); err_passive = 0; tick();
        @(negedge clk); chk("R6", irq_reg, 8'h20);
        hread();

        // R7: wake-up needs sleep and activity
        cur_req = "R7";
        bus_activity = 1; tick(2);
        @(negedge clk); chk("R7", irq_reg, 8'h00);
        sleep_mode = 1; tick();
        @(negedge clk); chk("R7", irq_reg, 8'h10);
        sleep_mode = 0; bus_activity = 0; hread();

        // R4: bus error lock
        cur_req = "R4";
        bus_err_evt = 1; tick(); bus_err_evt = 0;
        @(negedge clk); chk("R4", irq_reg, 8'h80);
        hread();
        bus_err_evt = 1; tick(); bus_err_evt = 0;
        @(negedge clk); chk("R4", irq_reg, 8'h00);
        bus_err_evt = 1; err_cap_rd = 1; tick(); bus_err_evt = 0; err_cap_rd = 0;
        @(negedge clk); chk("R4", irq_reg, 8'h00);
        bus_err_evt = 1; err_cap_rd = 1; tick(); bus_err_evt = 0; err_cap_rd = 0;
        @(negedge clk); chk("R4", irq_reg, 8'h80);
        hread(); bus_err_evt = 1; tick(); bus_err_evt = 0;
        @(negedge clk); chk("R4", irq_reg, 8'h00);
        err_cap_rd = 1; tick(); err_cap_rd = 0;

        // R5: arbitration lost lock
        cur_req = "R5";
        arb_lost_evt = 1; tick(); arb_lost_evt = 0; hread();
        arb_lost_evt = 1; tick(); arb_lost_evt = 0;
        @(negedge clk); chk("R5", irq_reg, 8'h00);
        arb_cap_rd = 1; tick(); arb_cap_rd = 0;
        arb_lost_evt = 1; tick(); arb_lost_evt = 0;
        @(negedge clk); chk("R5", irq_reg, 8'h40);
        arb_cap_rd = 1; hread(); arb_cap_rd = 0;

        // R11: receive level, not cleared by read
        cur_req = "R11";
        rx_count = 7'd8; tick(2);
        @(negedge clk); chk("R11", irq_reg, 8'h00);
        rx_count = 7'd9; tick();
        @(negedge clk); chk("R11", irq_reg, 8'h01);
        hread(); tick();
        @(negedge clk); chk("R11", irq_reg, 8'h01);
        rx_count = 0; hp_pending = 1; tick();
        @(negedge clk); chk("R11", irq_reg, 8'h01);
        hp_pending = 0; tick();
        @(negedge clk); chk("R11", irq_reg, 8'h00);

        // R3: set in the read cycle wins
        cur_req = "R3";
        overrun_stat = 1; tick(); overrun_stat = 0; tick();
        err_stat = 1; host_rd = 1; tick(); host_rd = 0;
        @(negedge clk); chk("R3", irq_reg, 8'h04);
        hread(); err_stat = 0; tick(); hread();

        // R12: disabled sources
        cur_req = "R12";
        int_en = 8'h00;
        overrun_stat = 1; tx_buf_free = 0; rx_count = 7'd100; bus_err_evt = 1;
        tick(); bus_err_evt = 0; tick();
        @(negedge clk); chk("R12", irq_reg, 8'h00);
        int_en = 8'hFF; tick();
        @(negedge clk); chk("R12", irq_reg, 8'h01);
        rx_count = 0; tick(); hread();

        // mixed pseudorandom traffic
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            bus_err_evt = r[0]; arb_lost_evt = r[1]; err_passive = r[2];
            sleep_mode = r[3]; bus_activity = r[4]; overrun_stat = r[5];
            err_stat = r[6] & r[7]; bus_stat = r[8]; tx_buf_free = r[9];
            rx_count = r[16:10]; rx_level = r[23:17]; hp_pending = r[24] & r[25];
            host_rd = r[26]; err_cap_rd = r[27] & r[28]; arb_cap_rd = r[29] & r[28];
            if (r[30] & r[31]) int_en = r[23:16];
            tick();
        end
        host_rd = 0; err_cap_rd = 0; arb_cap_rd = 0;
        tick(2);
        finish_run();
    end

endmodule